// File: doc/BRIEF.md
# DC Bus Fault Qualifier

This block sits between the DC bus current and voltage comparators of a motor drive and the commutation logic. Once per sample strobe it looks at two over-limit bits, one for bus current and one for bus voltage. Any sample with either bit set raises a temporary phase-disable output. That output lasts until the next sample, so the drive idles its phases for one sample period and resumes by itself if the next reading is clean.

Each quantity also has its own run counter of back-to-back over-limit samples. When a run reaches its threshold (five samples for current, ten for voltage, both parameters), a sticky fault flag is set. Either flag asserts a motor-stop output, and both flags go on the bus status report. The flags stay set until the bus master sends a clear pulse. That pulse drops both flags and empties both counters. Analog conversion and threshold comparison happen upstream.

Top module: `dcbus_fault_qual`

## Requirements
- R1: On every cycle with `sample_stb` high, `phase_hold` takes the OR of `over_cur` and `over_volt` one cycle later. It keeps that value until the next strobe.
- R2: `fault_cur` goes high one cycle after the strobe that completes `CUR_LIMIT` (default 5) consecutive strobes with `over_cur` high, and not earlier.
- R3: `fault_volt` goes high one cycle after the strobe that completes `VOLT_LIMIT` (default 10) consecutive strobes with `over_volt` high, and not earlier.
- R4: Once set, a fault flag stays high through any later samples, clean or not, until a clear pulse. `motor_stop` is high whenever either flag is high and low when both are low.
- R5: A one-cycle `clear_pulse` drops both fault flags and `motor_stop` in the following cycle, with or without a strobe, and empties both run counters.
- R6: A strobe with the over-limit bit low resets that quantity's run to zero. With the current threshold at 5, the sequence 4 over, 1 clean, 4 over leaves `fault_cur` low, and one more over sets it.
- R7: If `clear_pulse` and an over-limit strobe fall in the same cycle, the clear takes effect and that sample counts as the first of a new run. With the current threshold at 5, four more over samples then set `fault_cur`.
- R8: In cycles without `sample_stb`, the over-limit bits are ignored. They neither advance nor reset a run, and they do not change `phase_hold`.
- R9: The two quantities are qualified independently. A current run never sets `fault_volt`, and a voltage run never sets `fault_cur`.
- R10: After a synchronous active-low reset, `phase_hold`, `motor_stop`, `fault_cur` and `fault_volt` are all low and both runs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_stb | input | 1 | One-cycle pulse marking a valid comparator sample |
| over_cur | input | 1 | DC bus current above its limit |
| over_volt | input | 1 | DC bus voltage above its limit |
| clear_pulse | input | 1 | One-cycle request to clear both faults |
| phase_hold | output | 1 | Temporary phase disable for the current sample period |
| motor_stop | output | 1 | Motor must stay stopped while a fault is latched |
| fault_cur | output | 1 | Sticky overcurrent fault |
| fault_volt | output | 1 | Sticky overvoltage fault |

## Verification
The hardest situation to reach is a clear pulse that arrives on the same cycle as an over-limit sample while a fault is already latched. The clear must win, and that same sample must still start a new run. The bench first latches the current fault. It then drives one strobe with both `clear_pulse` and `over_cur` high. It confirms the flag dropped, then counts exactly three further over samples with the flag still low before the fourth sets it. A second subtle case is a run interrupted by cycles with over-limit bits high but no strobe. The bench checks that these cycles neither advance nor break the run.

// File: rtl/dcbus_fault_pkg.sv
// Package: shared channel indices and width helper for the DC bus
// fault qualifier.
package dcbus_fault_pkg;

    // Channel index of each supervised bus quantity.
    typedef enum int {
        CH_CUR  = 0,
        CH_VOLT = 1
    } bus_ch_e;

    localparam int NUM_CH = 2;

    // Bits needed to hold a run count from 0 up to and including limit.
    function automatic int run_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/dcbus_run_qualifier.sv
// Module: dcbus_run_qualifier
// Counts back-to-back over-limit samples of one bus quantity and latches
// a sticky fault when the run reaches LIMIT.
// Assumes: sample_stb and clear are single-cycle pulses in the clk domain;
// LIMIT >= 1. The count saturates at LIMIT. A clean sample empties it.
// A clear empties it, and a simultaneous over sample restarts it at one.
module dcbus_run_qualifier #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_stb,
    input  logic over,
    input  logic clear,
    output logic fault_o
);
    import dcbus_fault_pkg::*;

    localparam int CW = run_width(LIMIT);
    localparam logic [CW-1:0] SAT_CNT  = CW'(LIMIT);
    localparam logic [CW-1:0] LAST_CNT = CW'(LIMIT - 1);
    localparam logic [CW-1:0] ONE_CNT  = CW'(1);

    logic [CW-1:0] run_cnt;
    logic          fault_q;
    logic          hit;

    // Purpose: an over-limit reading that belongs to a valid sample.
    always_comb begin
        hit = sample_stb & over;
    end

    // Purpose: advance, saturate or empty the run and manage the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            fault_q <= 1'b0;
        end else if (clear) begin
            run_cnt <= hit ? ONE_CNT : '0;
            fault_q <= hit && (LIMIT == 1);
        end else if (sample_stb) begin
            if (over) begin
                if (run_cnt != SAT_CNT) begin
                    run_cnt <= run_cnt + ONE_CNT;
                end
                if (run_cnt == LAST_CNT) begin
                    fault_q <= 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

    assign fault_o = fault_q;

endmodule

// File: rtl/dcbus_phase_hold.sv
// Module: dcbus_phase_hold
// Raises the temporary phase-disable for one sample period whenever any
// channel reports an over-limit reading on a strobe.
// Assumes: over bits are valid only while sample_stb is high. The output
// holds between strobes.
module dcbus_phase_hold #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic [NUM_CH-1:0] over_vec,
    output logic              hold_o
);
    logic hold_q;

    // Purpose: capture the OR of all over bits at each sample, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (sample_stb) begin
            hold_q <= |over_vec;
        end
    end

    assign hold_o = hold_q;

endmodule

// File: rtl/dcbus_stop_gate.sv
// Module: dcbus_stop_gate
// Combines the latched faults of all channels into the motor-stop request.
// Assumes: fault inputs are registered upstream; this stage is pure logic.
module dcbus_stop_gate #(
    parameter int NUM_CH = 2
) (
    input  logic [NUM_CH-1:0] faults,
    output logic              stop_o
);
    // Purpose: stop the motor while any channel holds a fault.
    always_comb begin
        stop_o = |faults;
    end

endmodule

// File: rtl/dcbus_fault_qual.sv
// Module: dcbus_fault_qual (top)
// Two-tier DC bus protection. Every over-limit sample raises a one-period
// phase hold. A run of CUR_LIMIT current or VOLT_LIMIT voltage exceedances
// latches a sticky fault that stops the motor until clear_pulse.
// Assumes: comparators are already synchronous to clk; strobes and clears
// are single-cycle pulses.
module dcbus_fault_qual #(
    parameter int CUR_LIMIT  = 5,
    parameter int VOLT_LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_stb,
    input  logic over_cur,
    input  logic over_volt,
    input  logic clear_pulse,
    output logic phase_hold,
    output logic motor_stop,
    output logic fault_cur,
    output logic fault_volt
);
    import dcbus_fault_pkg::*;

    logic [NUM_CH-1:0] over_vec;
    logic [NUM_CH-1:0] fault_vec;

    // Purpose: gather comparator bits into channel order.
    always_comb begin
        over_vec          = '0;
        over_vec[CH_CUR]  = over_cur;
        over_vec[CH_VOLT] = over_volt;
    end

    // One run qualifier per channel, threshold picked by channel index.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int LIM = (g == CH_CUR) ? CUR_LIMIT : VOLT_LIMIT;
        dcbus_run_qualifier #(
            .LIMIT(LIM)
        ) u_qual (
            .clk       (clk),
            .rst_n     (rst_n),
            .sample_stb(sample_stb),
            .over      (over_vec[g]),
            .clear     (clear_pulse),
            .fault_o   (fault_vec[g])
        );
    end

    dcbus_phase_hold #(
        .NUM_CH(NUM_CH)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_stb(sample_stb),
        .over_vec  (over_vec),
        .hold_o    (phase_hold)
    );

    dcbus_stop_gate #(
        .NUM_CH(NUM_CH)
    ) u_stop (
        .faults(fault_vec),
        .stop_o(motor_stop)
    );

    assign fault_cur  = fault_vec[CH_CUR];
    assign fault_volt = fault_vec[CH_VOLT];

endmodule

// File: rtl/dcbus_fault_qual_chk.sv
// Module: dcbus_fault_qual_chk
// Property checker for dcbus_fault_qual, attached by bind. It keeps its own
// port-level run counters to judge when a fault may rise.
module dcbus_fault_qual_chk #(
    parameter int CUR_LIMIT  = 5,
    parameter int VOLT_LIMIT = 10
) (
    input logic clk,
    input logic rst_n,
    input logic sample_stb,
    input logic over_cur,
    input logic over_volt,
    input logic clear_pulse,
    input logic phase_hold,
    input logic motor_stop,
    input logic fault_cur,
    input logic fault_volt
);
    logic [7:0] seen_cur;
    logic [7:0] seen_volt;

    // Purpose: count consecutive over samples per channel as seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_cur  <= '0;
            seen_volt <= '0;
        end else begin
            if (clear_pulse) begin
                seen_cur  <= (sample_stb && over_cur)  ? 8'd1 : 8'd0;
                seen_volt <= (sample_stb && over_volt) ? 8'd1 : 8'd0;
            end else if (sample_stb) begin
                seen_cur  <= over_cur  ? ((seen_cur  == 8'hFF) ? seen_cur  : seen_cur  + 8'd1) : 8'd0;
                seen_volt <= over_volt ? ((seen_volt == 8'hFF) ? seen_volt : seen_volt + 8'd1) : 8'd0;
            end
        end
    end

    p_hold_tracks_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> (phase_hold == $past(over_cur || over_volt)));

    p_cur_rise_on_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_cur) |-> (seen_cur == 8'(CUR_LIMIT)));

    p_volt_rise_on_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_volt) |-> (seen_volt == 8'(VOLT_LIMIT)));

    p_cur_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_cur && !clear_pulse) |=> fault_cur);

    p_volt_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_volt && !clear_pulse) |=> fault_volt);

    p_stop_with_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_cur || fault_volt) |-> motor_stop);

    p_no_stop_without_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_cur && !fault_volt) |-> !motor_stop);

    p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse |=> (!fault_cur && !fault_volt));

    p_idle_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_stb && !clear_pulse) |=> ($stable(phase_hold) && $stable(fault_cur) && $stable(fault_volt)));

endmodule

bind dcbus_fault_qual dcbus_fault_qual_chk #(
    .CUR_LIMIT (CUR_LIMIT),
    .VOLT_LIMIT(VOLT_LIMIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .over_cur   (over_cur),
    .over_volt  (over_volt),
    .clear_pulse(clear_pulse),
    .phase_hold (phase_hold),
    .motor_stop (motor_stop),
    .fault_cur  (fault_cur),
    .fault_volt (fault_volt)
);

// File: tb/test_dcbus_fault_qual.sv
// Directed bench for dcbus_fault_qual: one task per scenario.
module test_dcbus_fault_qual;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_stb = 1'b0;
    logic over_cur = 1'b0;
    logic over_volt = 1'b0;
    logic clear_pulse = 1'b0;
    logic phase_hold, motor_stop, fault_cur, fault_volt;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    dcbus_fault_qual #(.CUR_LIMIT(5), .VOLT_LIMIT(10)) i_dcbus_fault_qual (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .over_cur(over_cur), .over_volt(over_volt), .clear_pulse(clear_pulse),
        .phase_hold(phase_hold), .motor_stop(motor_stop),
        .fault_cur(fault_cur), .fault_volt(fault_volt)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // One strobe; outputs are sampled at the next falling edge.
    task automatic sample(input logic oc, input logic ov, input logic clr);
        @(negedge clk);
        sample_stb  = 1'b1;
        over_cur    = oc;
        over_volt   = ov;
        clear_pulse = clr;
        @(negedge clk);
        sample_stb  = 1'b0;
        over_cur    = 1'b0;
        over_volt   = 1'b0;
        clear_pulse = 1'b0;
    endtask

    task automatic clear_only();
        @(negedge clk);
        clear_pulse = 1'b1;
        @(negedge clk);
        clear_pulse = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "phase_hold", phase_hold, 1'b0);
        check("R10", "motor_stop", motor_stop, 1'b0);
        check("R10", "fault_cur", fault_cur, 1'b0);
        check("R10", "fault_volt", fault_volt, 1'b0);
    endtask

    task automatic t_hold();
        sample(1'b1, 1'b0, 1'b0);
        check("R1", "hold after current over", phase_hold, 1'b1);
        repeat (3) @(negedge clk);
        check("R1", "hold kept between strobes", phase_hold, 1'b1);
        sample(1'b0, 1'b0, 1'b0);
        check("R1", "hold released by clean sample", phase_hold, 1'b0);
        sample(1'b0, 1'b1, 1'b0);
        check("R1", "hold after voltage over", phase_hold, 1'b1);
        sample(1'b0, 1'b0, 1'b0);
        clear_only();
    endtask

    task automatic t_idle_ignored();
        for (int i = 0; i < 4; i++) sample(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        over_cur = 1'b0;
        repeat (6) @(negedge clk);
        check("R8", "clean bits without strobe keep hold", phase_hold, 1'b1);
        check("R8", "run not broken by idle", fault_cur, 1'b0);
        sample(1'b1, 1'b0, 1'b0);
        check("R8", "run survives unstrobed cycles", fault_cur, 1'b1);
        clear_only();
        sample(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        over_cur = 1'b1;
        repeat (8) @(negedge clk);
        over_cur = 1'b0;
        check("R8", "over bits without strobe leave hold low", phase_hold, 1'b0);
        check("R8", "over bits without strobe set no fault", fault_cur, 1'b0);
    endtask

    task automatic t_cur_run();
        clear_only();
        for (int i = 0; i < 4; i++) sample(1'b1, 1'b0, 1'b0);
        check("R2", "no fault after 4", fault_cur, 1'b0);
        check("R2", "no stop after 4", motor_stop, 1'b0);
        sample(1'b1, 1'b0, 1'b0);
        check("R2", "fault after 5", fault_cur, 1'b1);
        check("R4", "stop with current fault", motor_stop, 1'b1);
        check("R9", "voltage fault untouched", fault_volt, 1'b0);
        for (int i = 0; i < 3; i++) sample(1'b0, 1'b0, 1'b0);
        check("R4", "current fault sticky", fault_cur, 1'b1);
        check("R4", "stop sticky", motor_stop, 1'b1);
        clear_only();
        check("R5", "clear drops current fault", fault_cur, 1'b0);
        check("R5", "clear drops stop", motor_stop, 1'b0);
    endtask

    task automatic t_volt_run();
        for (int i = 0; i < 9; i++) sample(1'b0, 1'b1, 1'b0);
        check("R3", "no fault after 9", fault_volt, 1'b0);
        sample(1'b0, 1'b1, 1'b0);
        check("R3", "fault after 10", fault_volt, 1'b1);
        check("R9", "current fault untouched", fault_cur, 1'b0);
        check("R4", "stop with voltage fault", motor_stop, 1'b1);
        clear_only();
        check("R5", "clear drops voltage fault", fault_volt, 1'b0);
        for (int i = 0; i < 9; i++) sample(1'b0, 1'b1, 1'b0);
        check("R5", "clear emptied voltage run", fault_volt, 1'b0);
        clear_only();
    endtask

    task automatic t_run_reset();
        for (int i = 0; i < 4; i++) sample(1'b1, 1'b0, 1'b0);
        sample(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) sample(1'b1, 1'b0, 1'b0);
        check("R6", "broken run gives no fault", fault_cur, 1'b0);
        sample(1'b1, 1'b0, 1'b0);
        check("R6", "fifth after break sets fault", fault_cur, 1'b1);
    endtask

    task automatic t_clear_wins();
        sample(1'b1, 1'b0, 1'b1);
        check("R7", "clear wins over new exceedance", fault_cur, 1'b0);
        check("R7", "hold still raised", phase_hold, 1'b1);
        for (int i = 0; i < 3; i++) sample(1'b1, 1'b0, 1'b0);
        check("R7", "no fault after 1+3", fault_cur, 1'b0);
        sample(1'b1, 1'b0, 1'b0);
        check("R7", "fault after 1+4", fault_cur, 1'b1);
        clear_only();
    endtask

    task automatic t_mixed();
        for (int i = 0; i < 9; i++) sample(1'b1, 1'b1, 1'b0);
        check("R9", "both overs: current latched", fault_cur, 1'b1);
        check("R9", "both overs: voltage not yet", fault_volt, 1'b0);
        sample(1'b0, 1'b1, 1'b0);
        check("R9", "voltage latches at 10", fault_volt, 1'b1);
        clear_only();
        check("R5", "clear drops both", fault_cur | fault_volt, 1'b0);
    endtask

    initial begin
        t_reset();
        t_hold();
        t_idle_ignored();
        t_cur_run();
        t_volt_run();
        t_run_reset();
        t_clear_wins();
        t_mixed();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule